// File: doc/BRIEF.md
# Vector Step Execute Unit

This unit carries out a single instruction that either reports or advances the loop counters of a vector engine. A 32-bit instruction word is presented with a one-cycle `valid_i` strobe. The current vectorisation state comes in on the input ports: source and destination element counters, source and destination sub-element counters, vector length, sub-vector length, and the two loop-ordering bits (pack for the source side, unpack for the destination side). The instruction may return one of four externally computed remap-shape offsets or one of the four counters. It may advance both counters by one element, or it may rewrite the ordering bits. The unit answers one cycle later with a 64-bit value for the target register, an optional condition field, and the state to write back.

Element advancing is done by two instances of a shared step iterator, one per side. Each walks the sub-element loop and the element loop in an order chosen by its ordering bit. When asked, it passes over masked-out elements of the predicate mask for its side. The surrounding pipeline owns the state register, the register file and the predicate masks. This unit only computes values and write enables.

Top module: `svstep_unit`

## Requirements
- R1: Instruction fields use LSB-0 numbering: primary opcode `insn_i[31:26]` (must equal parameter `OPC_PRI`, default 22), target register `insn_i[25:21]`, selector `insn_i[15:9]`, commit bit `insn_i[6]`, extended opcode `insn_i[5:1]` (must equal `OPC_EXT`, default 19), condition-record bit `insn_i[0]`. If either opcode differs, `illegal_o` is 1, all write enables are 0 and `rt_data_o` is 0.
- R2: Selector values 1, 2, 3 and 4 return, zero-extended, shape offset 0 to 3. Shape k sits at `shape_ofs_i[k*OFS_W +: OFS_W]`.
- R3: Selector values 5, 6, 7 and 8 return, zero-extended, the source element counter, the destination element counter, the source sub-element counter and the destination sub-element counter, in that order.
- R4: Selector 0 returns 0 and advances both sides. With the ordering bit clear, the sub-element counter advances first. When it already equals the sub-vector length field it resets to 0 and the element counter moves on. Past element vl-1 the element counter wraps to 0.
- R5: With the ordering bit set (pack for source, unpack for destination), the element counter advances first. At vl-1 it wraps to 0 and the sub-element counter increments. If the sub-element counter already equals the sub-vector length field, it is left unchanged.
- R6: When a side's skip input is 1, its element counter moves to the next higher element whose mask bit is 1, or wraps to 0 if none remains below vl. When the skip input is 0, the mask is ignored.
- R7: Selector values 12 to 15 write the ordering bits: pack gets selector bit 0 and unpack gets selector bit 1. The result is `{62'b0, pack, unpack}` of the new values.
- R8: With the commit bit 0, `state_we_o` is 0 and the state outputs equal the state inputs. The result is still produced.
- R9: Selector 0 with commit 0 and condition-record 0 leaves every write enable at 0.
- R10: Selector values 9 to 11 and 16 to 127 return 0 with the register write enabled and `state_we_o` at 0.
- R11: With condition-record 1, `cr0_we_o` is 1 and `cr0_o` = {LT,GT,EQ,SO} = {0,0,E,0}. E is 1 when, in the input state, either the source element counter is vl-1 and its sub-counter equals the sub-vector length, or the same holds on the destination side. Without condition-record, `cr0_o` is 0.
- R12: All outputs are registered. A request accepted at one clock edge appears at the next edge with `valid_o` high, and back-to-back requests are accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Instruction word |
| srcstep_i | input | STEP_W | Source element counter |
| dststep_i | input | STEP_W | Destination element counter |
| ssub_i | input | SUB_W | Source sub-element counter |
| dsub_i | input | SUB_W | Destination sub-element counter |
| vl_i | input | VL_W | Vector length (1..MAXVL) |
| subvl_i | input | SUB_W | Sub-vector length minus one |
| pack_i | input | 1 | Source ordering bit |
| unpack_i | input | 1 | Destination ordering bit |
| shape_ofs_i | input | 4*OFS_W | Four remap-shape offsets |
| src_mask_i | input | MAXVL | Source predicate mask |
| dst_mask_i | input | MAXVL | Destination predicate mask |
| src_skip_i | input | 1 | Pass over masked-out source elements |
| dst_skip_i | input | 1 | Pass over masked-out destination elements |
| valid_o | output | 1 | Result present |
| illegal_o | output | 1 | Opcode mismatch |
| rt_we_o | output | 1 | Target register write enable |
| rt_addr_o | output | 5 | Target register number |
| rt_data_o | output | 64 | Target register value |
| cr0_we_o | output | 1 | Condition field write enable |
| cr0_o | output | 4 | Condition field {LT,GT,EQ,SO} |
| state_we_o | output | 1 | State write-back enable |
| srcstep_o | output | STEP_W | New source element counter |
| dststep_o | output | STEP_W | New destination element counter |
| ssub_o | output | SUB_W | New source sub-element counter |
| dsub_o | output | SUB_W | New destination sub-element counter |
| pack_o | output | 1 | New source ordering bit |
| unpack_o | output | 1 | New destination ordering bit |

## Verification
The assertions assume a legal state on the inputs: vl between 1 and MAXVL, both element counters below vl, and both sub-counters no greater than the sub-vector length field. They also assume `valid_i` is low during reset, since the opcode and selector checks are judged against the instruction sampled one cycle before `valid_o`. The stimulus sets each state through one task that only loads such consistent tuples, mostly with vl of 4 or 5. It changes masks and skip inputs only between requests, so each expected value is fixed at the moment it is queued.

// File: rtl/svstep_pkg.sv
// Package: shared types for the vector step execute unit.
// Assumes instruction word fields in fixed positions (LSB-0 numbering).
package svstep_pkg;

    // Operating class selected by the 7-bit selector field.
    typedef enum logic [2:0] {
        M_STEP  = 3'd0,   // advance both iterators
        M_SHAPE = 3'd1,   // return a remap-shape offset
        M_COUNT = 3'd2,   // return one loop counter
        M_PACK  = 3'd3,   // rewrite ordering bits
        M_RSVD  = 3'd4    // reserved selector, returns zero
    } mode_e;

    // Decoded instruction fields.
    typedef struct packed {
        logic       op_ok;
        logic [4:0] rt;
        logic [6:0] svi;
        logic       vf;
        logic       rc;
        mode_e      mode;
    } dec_t;

endpackage

// File: rtl/svstep_decode.sv
// Module: svstep_decode
// Splits the instruction word into fields, checks both opcodes and
// classifies the selector. Purely combinational.
// Assumes LSB-0 bit numbering of insn_i.
module svstep_decode
    import svstep_pkg::*;
#(
    parameter int OPC_PRI = 22,
    parameter int OPC_EXT = 19
) (
    input  logic [31:0] insn_i,
    output dec_t        dec_o
);

    logic [6:0] svi;

    assign svi = insn_i[15:9];

    // Field extraction and opcode check.
    always_comb begin
        dec_o.op_ok = (insn_i[31:26] == 6'(OPC_PRI)) && (insn_i[5:1] == 5'(OPC_EXT));
        dec_o.rt    = insn_i[25:21];
        dec_o.svi   = svi;
        dec_o.vf    = insn_i[6];
        dec_o.rc    = insn_i[0];
        dec_o.mode  = M_RSVD;
        if (svi == 7'd0)
            dec_o.mode = M_STEP;
        else if (svi <= 7'd4)
            dec_o.mode = M_SHAPE;
        else if (svi <= 7'd8)
            dec_o.mode = M_COUNT;
        else if (svi[6:2] == 5'b00011)
            dec_o.mode = M_PACK;
    end

endmodule

// File: rtl/svstep_iter.sv
// Module: svstep_iter
// One step of a two-level loop (elements x sub-elements). The ordering
// input picks which level moves first; an optional predicate skip passes
// over masked-out elements. Purely combinational.
// Assumes 1 <= vl_i <= MAXVL, step_i < vl_i and sub_i <= subvl_i.
module svstep_iter #(
    parameter int MAXVL = 64,
    parameter int SUB_W = 2,
    localparam int STEP_W = $clog2(MAXVL),
    localparam int VL_W   = $clog2(MAXVL + 1)
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [SUB_W-1:0]  sub_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [SUB_W-1:0]  subvl_i,
    input  logic              elem_first_i,
    input  logic [MAXVL-1:0]  mask_i,
    input  logic              skip_i,
    output logic [STEP_W-1:0] step_o,
    output logic [SUB_W-1:0]  sub_o,
    output logic              wrap_o
);

    logic              found;
    logic [STEP_W-1:0] cand;
    logic              sub_end;

    assign sub_end = (sub_i == subvl_i);

    // Find the lowest eligible element above the current one, below vl.
    always_comb begin
        found = 1'b0;
        cand  = '0;
        for (int s = 0; s < MAXVL; s++) begin
            if (!found && (s > int'(step_i)) && (s < int'(vl_i))
                && (mask_i[s] || !skip_i)) begin
                found = 1'b1;
                cand  = STEP_W'(s);
            end
        end
    end

    // Choose the next counters according to loop ordering.
    always_comb begin
        step_o = step_i;
        sub_o  = sub_i;
        wrap_o = 1'b0;
        if (elem_first_i) begin
            if (found) begin
                step_o = cand;
            end else begin
                step_o = '0;
                if (sub_end)
                    wrap_o = 1'b1;
                else
                    sub_o = sub_i + 1'b1;
            end
        end else begin
            if (!sub_end) begin
                sub_o = sub_i + 1'b1;
            end else begin
                sub_o = '0;
                if (found) begin
                    step_o = cand;
                end else begin
                    step_o = '0;
                    wrap_o = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/svstep_unit.sv
// Module: svstep_unit (top)
// Executes the vector step instruction: decodes it, selects the result,
// steps the source and destination iterators, computes the loop-end flag
// and registers every output for one cycle of latency.
// Assumes the caller holds the state register and supplies a legal state.
module svstep_unit
    import svstep_pkg::*;
#(
    parameter int MAXVL   = 64,
    parameter int SUB_W   = 2,
    parameter int OFS_W   = 7,
    parameter int OPC_PRI = 22,
    parameter int OPC_EXT = 19,
    localparam int STEP_W = $clog2(MAXVL),
    localparam int VL_W   = $clog2(MAXVL + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic [31:0]          insn_i,
    input  logic [STEP_W-1:0]    srcstep_i,
    input  logic [STEP_W-1:0]    dststep_i,
    input  logic [SUB_W-1:0]     ssub_i,
    input  logic [SUB_W-1:0]     dsub_i,
    input  logic [VL_W-1:0]      vl_i,
    input  logic [SUB_W-1:0]     subvl_i,
    input  logic                 pack_i,
    input  logic                 unpack_i,
    input  logic [4*OFS_W-1:0]   shape_ofs_i,
    input  logic [MAXVL-1:0]     src_mask_i,
    input  logic [MAXVL-1:0]     dst_mask_i,
    input  logic                 src_skip_i,
    input  logic                 dst_skip_i,
    output logic                 valid_o,
    output logic                 illegal_o,
    output logic                 rt_we_o,
    output logic [4:0]           rt_addr_o,
    output logic [63:0]          rt_data_o,
    output logic                 cr0_we_o,
    output logic [3:0]           cr0_o,
    output logic                 state_we_o,
    output logic [STEP_W-1:0]    srcstep_o,
    output logic [STEP_W-1:0]    dststep_o,
    output logic [SUB_W-1:0]     ssub_o,
    output logic [SUB_W-1:0]     dsub_o,
    output logic                 pack_o,
    output logic                 unpack_o
);

    dec_t dec;

    logic [STEP_W-1:0] src_nx, dst_nx;
    logic [SUB_W-1:0]  ssub_nx, dsub_nx;
    logic              src_wrap, dst_wrap;

    logic              legal, commit, is_nop, loop_end;
    logic [63:0]       result;
    logic [VL_W-1:0]   last_idx;

    logic [STEP_W-1:0] srcstep_d, dststep_d;
    logic [SUB_W-1:0]  ssub_d, dsub_d;
    logic              pack_d, unpack_d;

    svstep_decode #(.OPC_PRI(OPC_PRI), .OPC_EXT(OPC_EXT)) u_dec (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    svstep_iter #(.MAXVL(MAXVL), .SUB_W(SUB_W)) u_src_iter (
        .step_i       (srcstep_i),
        .sub_i        (ssub_i),
        .vl_i         (vl_i),
        .subvl_i      (subvl_i),
        .elem_first_i (pack_i),
        .mask_i       (src_mask_i),
        .skip_i       (src_skip_i),
        .step_o       (src_nx),
        .sub_o        (ssub_nx),
        .wrap_o       (src_wrap)
    );

    svstep_iter #(.MAXVL(MAXVL), .SUB_W(SUB_W)) u_dst_iter (
        .step_i       (dststep_i),
        .sub_i        (dsub_i),
        .vl_i         (vl_i),
        .subvl_i      (subvl_i),
        .elem_first_i (unpack_i),
        .mask_i       (dst_mask_i),
        .skip_i       (dst_skip_i),
        .step_o       (dst_nx),
        .sub_o        (dsub_nx),
        .wrap_o       (dst_wrap)
    );

    assign last_idx = vl_i - 1'b1;
    assign legal    = valid_i && dec.op_ok;
    assign is_nop   = (dec.svi == 7'd0) && !dec.vf && !dec.rc;
    assign commit   = legal && dec.vf && ((dec.mode == M_STEP) || (dec.mode == M_PACK));

    // Loop-end test on the incoming state, either side.
    always_comb begin
        loop_end = (((VL_W)'(srcstep_i) == last_idx) && (ssub_i == subvl_i))
                || (((VL_W)'(dststep_i) == last_idx) && (dsub_i == subvl_i));
    end

    // Result value selected by the operating class.
    always_comb begin
        result = '0;
        unique case (dec.mode)
            M_SHAPE: begin
                unique case (dec.svi[2:0])
                    3'd1:    result = 64'(shape_ofs_i[0*OFS_W +: OFS_W]);
                    3'd2:    result = 64'(shape_ofs_i[1*OFS_W +: OFS_W]);
                    3'd3:    result = 64'(shape_ofs_i[2*OFS_W +: OFS_W]);
                    default: result = 64'(shape_ofs_i[3*OFS_W +: OFS_W]);
                endcase
            end
            M_COUNT: begin
                unique case (dec.svi[3:0])
                    4'd5:    result = 64'(srcstep_i);
                    4'd6:    result = 64'(dststep_i);
                    4'd7:    result = 64'(ssub_i);
                    default: result = 64'(dsub_i);
                endcase
            end
            M_PACK:  result = {62'b0, dec.svi[0], dec.svi[1]};
            default: result = '0;
        endcase
    end

    // Next state: inputs unless a committed step or ordering write.
    always_comb begin
        srcstep_d = srcstep_i;
        dststep_d = dststep_i;
        ssub_d    = ssub_i;
        dsub_d    = dsub_i;
        pack_d    = pack_i;
        unpack_d  = unpack_i;
        if (commit && (dec.mode == M_STEP)) begin
            srcstep_d = src_nx;
            dststep_d = dst_nx;
            ssub_d    = ssub_nx;
            dsub_d    = dsub_nx;
        end else if (commit && (dec.mode == M_PACK)) begin
            pack_d   = dec.svi[0];
            unpack_d = dec.svi[1];
        end
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o    <= 1'b0;
            illegal_o  <= 1'b0;
            rt_we_o    <= 1'b0;
            rt_addr_o  <= '0;
            rt_data_o  <= '0;
            cr0_we_o   <= 1'b0;
            cr0_o      <= '0;
            state_we_o <= 1'b0;
            srcstep_o  <= '0;
            dststep_o  <= '0;
            ssub_o     <= '0;
            dsub_o     <= '0;
            pack_o     <= 1'b0;
            unpack_o   <= 1'b0;
        end else begin
            valid_o    <= valid_i;
            illegal_o  <= valid_i && !dec.op_ok;
            rt_we_o    <= legal && !is_nop;
            rt_addr_o  <= dec.rt;
            rt_data_o  <= legal ? result : 64'd0;
            cr0_we_o   <= legal && dec.rc;
            cr0_o      <= (legal && dec.rc) ? {2'b00, loop_end, 1'b0} : 4'd0;
            state_we_o <= commit;
            srcstep_o  <= srcstep_d;
            dststep_o  <= dststep_d;
            ssub_o     <= ssub_d;
            dsub_o     <= dsub_d;
            pack_o     <= pack_d;
            unpack_o   <= unpack_d;
        end
    end

endmodule

// File: rtl/svstep_unit_chk.sv
// Module: svstep_unit_chk
// Checker for svstep_unit, bound to every instance of it.
// Assumes valid_i is low while reset is asserted.
module svstep_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic [31:0] insn_i,
    input logic        valid_o,
    input logic        illegal_o,
    input logic        rt_we_o,
    input logic [63:0] rt_data_o,
    input logic        cr0_we_o,
    input logic [3:0]  cr0_o,
    input logic        state_we_o
);

    // R1: an opcode mismatch writes nothing.
    a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!rt_we_o && !cr0_we_o && !state_we_o && rt_data_o == 64'd0));

    // R12: every request is answered on the next edge.
    a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    // R8: a non-committing request never writes state.
    a_r8_query_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !$past(insn_i[6])) |-> !state_we_o);

    // R4: the step selector always returns zero.
    a_r4_step_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !illegal_o && $past(insn_i[15:9]) == 7'd0) |-> rt_data_o == 64'd0);

    // R10: reserved selectors return zero and leave state alone.
    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !illegal_o && ($past(insn_i[15:9]) >= 7'd16
            || ($past(insn_i[15:9]) >= 7'd9 && $past(insn_i[15:9]) <= 7'd11)))
        |-> (rt_data_o == 64'd0 && !state_we_o));

    // R11: only the EQ position of the condition field can be set.
    a_r11_cr0_form: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_we_o |-> (cr0_o[3:2] == 2'b00 && cr0_o[0] == 1'b0));

    // R11: condition field is zero when not written.
    a_r11_cr0_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cr0_we_o |-> cr0_o == 4'd0);

endmodule

bind svstep_unit svstep_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .insn_i     (insn_i),
    .valid_o    (valid_o),
    .illegal_o  (illegal_o),
    .rt_we_o    (rt_we_o),
    .rt_data_o  (rt_data_o),
    .cr0_we_o   (cr0_we_o),
    .cr0_o      (cr0_o),
    .state_we_o (state_we_o)
);

// File: tb/test_svstep_unit.sv
`timescale 1ns/1ps
// Scoreboard bench for svstep_unit: the driver queues expected outputs
// from a loop-walking model, the monitor compares each result.
module test_svstep_unit;

    localparam int MAXVL  = 64;
    localparam int SUB_W  = 2;
    localparam int OFS_W  = 7;
    localparam int STEP_W = $clog2(MAXVL);
    localparam int VL_W   = $clog2(MAXVL + 1);
    localparam int PO     = 22;
    localparam int XO     = 19;
    localparam int EXP_W  = 1 + 1 + 5 + 64 + 1 + 4 + 1 + 2*STEP_W + 2*SUB_W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [STEP_W-1:0] srcstep_i = '0, dststep_i = '0;
    logic [SUB_W-1:0] ssub_i = '0, dsub_i = '0, subvl_i = '0;
    logic [VL_W-1:0] vl_i = VL_W'(4);
    logic pack_i = 1'b0, unpack_i = 1'b0;
    logic [4*OFS_W-1:0] shape_ofs_i = '0;
    logic [MAXVL-1:0] src_mask_i = '1, dst_mask_i = '1;
    logic src_skip_i = 1'b0, dst_skip_i = 1'b0;

    logic valid_o, illegal_o, rt_we_o, cr0_we_o, state_we_o, pack_o, unpack_o;
    logic [4:0] rt_addr_o;
    logic [63:0] rt_data_o;
    logic [3:0] cr0_o;
    logic [STEP_W-1:0] srcstep_o, dststep_o;
    logic [SUB_W-1:0] ssub_o, dsub_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [EXP_W-1:0] exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    svstep_unit i_svstep_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i),
        .srcstep_i(srcstep_i), .dststep_i(dststep_i), .ssub_i(ssub_i), .dsub_i(dsub_i),
        .vl_i(vl_i), .subvl_i(subvl_i), .pack_i(pack_i), .unpack_i(unpack_i),
        .shape_ofs_i(shape_ofs_i), .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i),
        .src_skip_i(src_skip_i), .dst_skip_i(dst_skip_i),
        .valid_o(valid_o), .illegal_o(illegal_o), .rt_we_o(rt_we_o), .rt_addr_o(rt_addr_o),
        .rt_data_o(rt_data_o), .cr0_we_o(cr0_we_o), .cr0_o(cr0_o), .state_we_o(state_we_o),
        .srcstep_o(srcstep_o), .dststep_o(dststep_o), .ssub_o(ssub_o), .dsub_o(dsub_o),
        .pack_o(pack_o), .unpack_o(unpack_o)
    );

    // Build an instruction word from its fields.
    function automatic logic [31:0] mk(int po, int rt, int svi, bit vf, int xo, bit rc);
        return {6'(po), 5'(rt), 5'd0, 7'(svi), 2'd0, vf, 5'(xo), rc};
    endfunction

    // Reference walk of one side, written as an explicit search loop.
    task automatic ref_walk(input int step, input int sub, input bit elem_first,
                            input logic [MAXVL-1:0] mask, input bit skip,
                            output int nstep, output int nsub);
        int vl = int'(vl_i);
        int sv = int'(subvl_i);
        nsub = sub;
        if (elem_first || sub == sv) begin
            if (!elem_first) nsub = 0;
            while (1) begin
                if (step == vl - 1) begin
                    step = 0;
                    if (elem_first && sub != sv) nsub = sub + 1;
                    break;
                end
                step++;
                if (!skip || mask[step]) break;
            end
        end else begin
            nsub = sub + 1;
        end
        nstep = step;
    endtask

    // Driver: apply one request and queue its expected outputs.
    task automatic issue(input string tag, input logic [31:0] insn);
        int svi = int'(insn[15:9]);
        bit vf = insn[6], rc = insn[0];
        bit ok = (insn[31:26] == 6'(PO)) && (insn[5:1] == 5'(XO));
        bit nop = (svi == 0) && !vf && !rc;
        bit eq;
        logic [63:0] rd = '0;
        bit swe = 0;
        int ns = int'(srcstep_i), nd = int'(dststep_i);
        int nss = int'(ssub_i), nds = int'(dsub_i);
        bit np = pack_i, nu = unpack_i;
        eq = (int'(srcstep_i) == int'(vl_i) - 1 && ssub_i == subvl_i)
          || (int'(dststep_i) == int'(vl_i) - 1 && dsub_i == subvl_i);
        if (ok) begin
            if (svi >= 1 && svi <= 4) rd = 64'(shape_ofs_i[(svi-1)*OFS_W +: OFS_W]);
            else if (svi == 5) rd = 64'(srcstep_i);
            else if (svi == 6) rd = 64'(dststep_i);
            else if (svi == 7) rd = 64'(ssub_i);
            else if (svi == 8) rd = 64'(dsub_i);
            else if (svi >= 12 && svi <= 15) rd = {62'b0, 1'(svi), 1'(svi >> 1)};
            if (vf && svi == 0) begin
                swe = 1;
                ref_walk(int'(srcstep_i), int'(ssub_i), pack_i, src_mask_i, src_skip_i, ns, nss);
                ref_walk(int'(dststep_i), int'(dsub_i), unpack_i, dst_mask_i, dst_skip_i, nd, nds);
            end else if (vf && svi >= 12 && svi <= 15) begin
                swe = 1;
                np = 1'(svi);
                nu = 1'(svi >> 1);
            end
        end
        exp_q.push_back({!ok, ok && !nop, insn[25:21], rd, ok && rc,
                         (ok && rc) ? {2'b00, eq, 1'b0} : 4'd0, swe,
                         STEP_W'(ns), STEP_W'(nd), SUB_W'(nss), SUB_W'(nds), np, nu});
        tag_q.push_back(tag);
        insn_i = insn;
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    // Load a consistent state onto the input ports.
    task automatic set_state(int s, int d, int ss, int ds, int vl, int sv, bit p, bit u);
        srcstep_i = STEP_W'(s); dststep_i = STEP_W'(d);
        ssub_i = SUB_W'(ss); dsub_i = SUB_W'(ds);
        vl_i = VL_W'(vl); subvl_i = SUB_W'(sv);
        pack_i = p; unpack_i = u;
    endtask

    // Monitor: compare each result with the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            logic [EXP_W-1:0] act, exp;
            string tag;
            act = {illegal_o, rt_we_o, rt_addr_o, rt_data_o, cr0_we_o, cr0_o, state_we_o,
                   srcstep_o, dststep_o, ssub_o, dsub_o, pack_o, unpack_o};
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R12: unexpected result act=%h exp=none", act);
            end else begin
                exp = exp_q.pop_front();
                tag = tag_q.pop_front();
                if (act !== exp) begin
                    n_fail++;
                    $display("FAIL %s: act=%h exp=%h", tag, act, exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (valid_o !== 1'b0 || rt_we_o !== 1'b0 || state_we_o !== 1'b0 || cr0_o !== 4'd0) begin
            n_fail++;
            $display("FAIL R12 reset: act=%b%b%b%h exp=0000", valid_o, rt_we_o, state_we_o, cr0_o);
        end
        rst_n = 1'b1;
        @(negedge clk);
        shape_ofs_i = {7'd99, 7'd42, 7'd17, 7'd5};

        // R1 wrong primary and extended opcode
        issue("R1 bad primary", mk(PO + 1, 3, 0, 1, XO, 1));
        issue("R1 bad extended", mk(PO, 3, 5, 1, XO + 2, 0));
        // R2 shape offsets
        for (int k = 1; k <= 4; k++) issue("R2 shape", mk(PO, k, k, 0, XO, 0));
        // R3 counters
        set_state(2, 3, 1, 2, 5, 3, 0, 0);
        for (int k = 5; k <= 8; k++) issue("R3 counter", mk(PO, 7, k, 1, XO, 0));
        // R4 sub-element first, element advance, wrap
        set_state(1, 1, 0, 0, 4, 1, 0, 0);
        issue("R4 sub advance", mk(PO, 1, 0, 1, XO, 0));
        set_state(1, 2, 1, 1, 4, 1, 0, 0);
        issue("R4 elem advance", mk(PO, 1, 0, 1, XO, 0));
        set_state(3, 3, 1, 1, 4, 1, 0, 0);
        issue("R4 wrap", mk(PO, 1, 0, 1, XO, 0));
        // R5 element-first ordering
        set_state(1, 3, 0, 0, 4, 1, 1, 1);
        issue("R5 pack elem", mk(PO, 2, 0, 1, XO, 0));
        set_state(3, 3, 0, 1, 4, 1, 1, 1);
        issue("R5 pack sub and end", mk(PO, 2, 0, 1, XO, 0));
        // R6 predicate skip on and off
        src_mask_i = 64'b1001; dst_mask_i = 64'b10100;
        set_state(0, 0, 0, 0, 5, 0, 0, 0);
        src_skip_i = 1; dst_skip_i = 1;
        issue("R6 skip to set bit", mk(PO, 4, 0, 1, XO, 0));
        set_state(3, 2, 0, 0, 5, 0, 0, 0);
        issue("R6 skip past end", mk(PO, 4, 0, 1, XO, 0));
        src_skip_i = 0; dst_skip_i = 0;
        set_state(0, 0, 0, 0, 5, 0, 0, 0);
        issue("R6 mask ignored", mk(PO, 4, 0, 1, XO, 0));
        src_mask_i = '1; dst_mask_i = '1;
        // R7 ordering bit writes
        issue("R7 set pack", mk(PO, 5, 13, 1, XO, 0));
        issue("R7 set unpack", mk(PO, 5, 14, 1, XO, 0));
        issue("R7 set both", mk(PO, 5, 15, 1, XO, 0));
        // R8 query without commit
        set_state(1, 1, 0, 0, 4, 1, 0, 0);
        issue("R8 step query", mk(PO, 6, 0, 0, XO, 1));
        issue("R8 pack query", mk(PO, 6, 12, 0, XO, 0));
        // R9 no operation
        issue("R9 nop", mk(PO, 6, 0, 0, XO, 0));
        // R10 reserved selectors
        issue("R10 sel 9", mk(PO, 8, 9, 1, XO, 0));
        issue("R10 sel 20", mk(PO, 8, 20, 1, XO, 1));
        // R11 condition field at loop end and away from it
        set_state(3, 0, 1, 0, 4, 1, 0, 0);
        issue("R11 eq set", mk(PO, 9, 5, 0, XO, 1));
        set_state(2, 3, 1, 0, 4, 1, 0, 0);
        issue("R11 eq clear", mk(PO, 9, 0, 1, XO, 1));
        set_state(0, 3, 0, 1, 4, 1, 0, 0);
        issue("R11 dst end", mk(PO, 9, 0, 1, XO, 1));

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R12: missing results act=%0d exp=0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule